// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides whether a received Ethernet frame is kept. It looks only at the 48-bit destination address and takes it already extracted from the frame, with a one-cycle valid strobe. A small set of configuration inputs controls the decision: up to four station address entries, a 64-bit multicast hash table split into two 32-bit words, a hash enable, a broadcast block and a promiscuous accept-everything control.

The decision is registered. It appears one clock after the strobe as an accept flag and a 2-bit match code. The code tells the receive path why the frame was kept. A broadcast frame outranks a station hit, and a station hit outranks a hash hit. Configuration is sampled in the strobe cycle, so software can rewrite it between frames without disturbing a decision that is already in flight.

Top module: `dst_addr_filter`

## Requirements
- R1: `decision_valid_o` is high for exactly the one cycle that follows a cycle with `addr_valid_i` high. In every other cycle `accept_o` is 0 and `match_code_o` is 00.
- R2: Address byte k is carried on `dest_addr_i[8k+7:8k]`, and byte 0 is the first byte received. The hash index is six bits wide. Index bit i (0..5) is the XOR of `dest_addr_i` bits i, i+6, i+12 and so on, up to bit 47.
- R3: A hash index n below 32 selects `hash_lo_i[n]`. An index of 32 or more selects `hash_hi_i[n-32]`.
- R4: A frame is multicast when `dest_addr_i[0]` is 1. A multicast frame that is not broadcast and hits no station entry is accepted with code 11 when `hash_en_i` is 1 and the selected table bit is 1. When `hash_en_i` is 0, the table has no effect.
- R5: Station entry k is the pair `{sa_hi_i[16k+15:16k], sa_lo_i[32k+31:32k]}`, compared with `dest_addr_i`, so byte 0 sits in the low word's bits 7:0. A match on a non-zero entry gives accept with code 01. An all-zero entry never matches. Any other unicast address is rejected with code 00.
- R6: The all-ones address is accepted with code 10. When `no_bcast_i` is 1 and `copy_all_i` is 0, it is rejected with code 00.
- R7: When `copy_all_i` is 1, `accept_o` is 1 for every address. The code keeps its classification, and a broadcast reports 10 even when `no_bcast_i` is 1.
- R8: Classification priority is broadcast, then station match, then hash match.
- R9: All configuration is taken in the strobe cycle. A change made after the strobe does not alter the decision that follows it.
- R10: While `rst_ni` is low, `decision_valid_o`, `accept_o` and `match_code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_valid_i | input | 1 | Destination address strobe |
| dest_addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| hash_lo_i | input | 32 | Hash table bits 0..31 |
| hash_hi_i | input | 32 | Hash table bits 32..63 |
| copy_all_i | input | 1 | Accept every frame |
| no_bcast_i | input | 1 | Reject broadcast frames |
| hash_en_i | input | 1 | Enable multicast hash matching |
| sa_lo_i | input | 128 | Station entries, low words (bytes 0..3) |
| sa_hi_i | input | 64 | Station entries, high halves (bytes 4..5) |
| decision_valid_o | output | 1 | Decision strobe, one clock after the address strobe |
| accept_o | output | 1 | Frame accepted |
| match_code_o | output | 2 | 00 reject, 01 station, 10 broadcast, 11 hash |

## Verification
Several behaviours hold on every clock and are checked by assertions:
- The decision strobe follows the address strobe, and the outputs stay quiet otherwise.
- Copy-all always forces accept.
- A blocked broadcast is rejected.
- A zero address is never accepted without copy-all.
- Multicast with hashing disabled and no station hit is rejected.
- The parity of the hash index equals the parity of the whole address.

Other behaviours can only be shown by the bench scenarios, where a behavioural model is compared with the outputs every cycle:
- The exact index-to-table-bit mapping across both words.
- The priority between broadcast, station and hash matches.
- Station byte placement.
- Immunity of an in-flight decision to configuration rewrites.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;
  localparam int ADDR_W = 48;

  typedef enum logic [1:0] {
    CODE_REJECT  = 2'b00,
    CODE_STATION = 2'b01,
    CODE_BCAST   = 2'b10,
    CODE_HASH    = 2'b11
  } match_code_e;
endpackage

// File: rtl/dst_hash_idx.sv
module dst_hash_idx #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] dest_i,
  output logic [IDX_W-1:0]  idx_o
);
  for (genvar i = 0; i < IDX_W; i++) begin : g_fold
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int j = i; j < ADDR_W; j += IDX_W) acc ^= dest_i[j];
      idx_o[i] = acc;
    end
  end
endmodule

// File: rtl/dst_sa_match.sv
module dst_sa_match #(
  parameter int ADDR_W = 48,
  parameter int NUM_SA = 4,
  localparam int LO_W = 32,
  localparam int HI_W = ADDR_W - LO_W
) (
  input  logic [ADDR_W-1:0]      dest_i,
  input  logic [NUM_SA*LO_W-1:0] sa_lo_i,
  input  logic [NUM_SA*HI_W-1:0] sa_hi_i,
  output logic                   hit_o
);
  logic [NUM_SA-1:0] hit;

  for (genvar k = 0; k < NUM_SA; k++) begin : g_entry
    logic [ADDR_W-1:0] entry;
    assign entry  = {sa_hi_i[k*HI_W +: HI_W], sa_lo_i[k*LO_W +: LO_W]};
    // all-zero entry is an unused slot
    assign hit[k] = (entry != '0) && (entry == dest_i);
  end

  assign hit_o = |hit;
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import dst_filt_pkg::*;
#(
  parameter int NUM_SA     = 4,
  parameter int HASH_IDX_W = 6,
  localparam int HASH_N  = 1 << HASH_IDX_W,
  localparam int HWORD_W = HASH_N / 2,
  localparam int SA_LO_W = 32,
  localparam int SA_HI_W = ADDR_W - SA_LO_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      addr_valid_i,
  input  logic [ADDR_W-1:0]         dest_addr_i,
  input  logic [HWORD_W-1:0]        hash_lo_i,
  input  logic [HWORD_W-1:0]        hash_hi_i,
  input  logic                      copy_all_i,
  input  logic                      no_bcast_i,
  input  logic                      hash_en_i,
  input  logic [NUM_SA*SA_LO_W-1:0] sa_lo_i,
  input  logic [NUM_SA*SA_HI_W-1:0] sa_hi_i,
  output logic                      decision_valid_o,
  output logic                      accept_o,
  output logic [1:0]                match_code_o
);
  logic [HASH_IDX_W-1:0] hash_idx;
  logic [HASH_N-1:0]     table_w;
  logic                  table_hit, sa_hit, is_bcast, is_mcast;
  match_code_e           code_d;
  logic                  accept_d;

  dst_hash_idx #(.ADDR_W(ADDR_W), .IDX_W(HASH_IDX_W)) i_hash (
    .dest_i (dest_addr_i),
    .idx_o  (hash_idx)
  );

  dst_sa_match #(.ADDR_W(ADDR_W), .NUM_SA(NUM_SA)) i_sa (
    .dest_i  (dest_addr_i),
    .sa_lo_i (sa_lo_i),
    .sa_hi_i (sa_hi_i),
    .hit_o   (sa_hit)
  );

  assign table_w   = {hash_hi_i, hash_lo_i};
  assign table_hit = table_w[hash_idx];
  assign is_bcast  = &dest_addr_i;
  assign is_mcast  = dest_addr_i[0];

  always_comb begin
    if (is_bcast)
      code_d = (!no_bcast_i || copy_all_i) ? CODE_BCAST : CODE_REJECT;
    else if (sa_hit)
      code_d = CODE_STATION;
    else if (is_mcast && hash_en_i && table_hit)
      code_d = CODE_HASH;
    else
      code_d = CODE_REJECT;
    accept_d = copy_all_i || (code_d != CODE_REJECT);
  end

  // config is consumed only in the strobe cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
      match_code_o     <= 2'b00;
    end else begin
      decision_valid_o <= addr_valid_i;
      accept_o         <= addr_valid_i && accept_d;
      match_code_o     <= addr_valid_i ? code_d : CODE_REJECT;
    end
  end

  a_r1_valid_follows_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o == $past(addr_valid_i));
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> (!accept_o && match_code_o == 2'b00));
  a_r2_index_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i |-> ((^hash_idx) == (^dest_addr_i)));
  a_r7_copy_all_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && copy_all_i) |=> accept_o);
  a_r6_no_bcast_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && is_bcast && no_bcast_i && !copy_all_i) |=> !accept_o);
  a_r5_zero_never_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && dest_addr_i == '0 && !copy_all_i) |=> !accept_o);
  a_r4_hash_off_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && is_mcast && !is_bcast && !hash_en_i && !sa_hit && !copy_all_i)
      |=> (!accept_o && match_code_o == 2'b00));
endmodule

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld = 1'b0;
  logic [47:0]  dest = '0;
  logic [31:0]  hlo = '0, hhi = '0;
  logic         copy_all = 1'b0, no_bcast = 1'b0, hash_en = 1'b0;
  logic [127:0] sa_lo = '0;
  logic [63:0]  sa_hi = '0;
  logic         dv, acc;
  logic [1:0]   code;

  int    checks = 0, errors = 0, cycles = 0;
  string tag = "R10";
  logic       exp_dv, exp_acc;
  logic [1:0] exp_code;

  always #5 clk = ~clk;

  dst_addr_filter i_dst_addr_filter (
    .clk_i(clk), .rst_ni(rst_n), .addr_valid_i(vld), .dest_addr_i(dest),
    .hash_lo_i(hlo), .hash_hi_i(hhi), .copy_all_i(copy_all),
    .no_bcast_i(no_bcast), .hash_en_i(hash_en), .sa_lo_i(sa_lo),
    .sa_hi_i(sa_hi), .decision_valid_o(dv), .accept_o(acc),
    .match_code_o(code)
  );

  function automatic int hidx(input logic [47:0] a);
    int r = 0;
    for (int i = 0; i < 6; i++) begin
      int p = 0;
      for (int b = i; b < 48; b += 6) p = p ^ int'(a[b]);
      r = r | (p << i);
    end
    return r;
  endfunction

  function automatic logic [2:0] model(input logic [47:0] a);
    logic st = 1'b0;
    int n;
    logic tb;
    logic [1:0] c;
    for (int k = 0; k < 4; k++) begin
      logic [47:0] e;
      e = {sa_hi[k*16 +: 16], sa_lo[k*32 +: 32]};
      if (e != 0 && e == a) st = 1'b1;
    end
    n  = hidx(a);
    tb = (n < 32) ? hlo[n] : hhi[n-32];
    if (a == 48'hFFFF_FFFF_FFFF) c = (!no_bcast || copy_all) ? 2'd2 : 2'd0;
    else if (st) c = 2'd1;
    else if (a[0] && hash_en && tb) c = 2'd3;
    else c = 2'd0;
    return {copy_all || c != 0, c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_dv = 1'b0; exp_acc = 1'b0; exp_code = 2'd0;
    end else begin
      logic [2:0] m;
      m = model(dest);
      exp_dv   = vld;
      exp_acc  = vld && m[2];
      exp_code = vld ? m[1:0] : 2'd0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (dv !== exp_dv || acc !== exp_acc || code !== exp_code) begin
      errors++;
      $display("FAIL %s act v=%b a=%b c=%0d exp v=%b a=%b c=%0d",
               tag, dv, acc, code, exp_dv, exp_acc, exp_code);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act cycles=%0d exp done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic strobe(input logic [47:0] a);
    @(negedge clk); vld = 1'b1; dest = a;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic set_sa(input int k, input logic [47:0] a);
    sa_lo[k*32 +: 32] = a[31:0];
    sa_hi[k*16 +: 16] = a[47:32];
  endtask

  function automatic logic [47:0] rnd_mc();
    logic [47:0] a;
    a = {$urandom, $urandom};
    a[0] = 1'b1; a[47] = 1'b0;
    return a;
  endfunction

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    repeat (3) @(negedge clk);
    // R1: back-to-back strobes
    @(negedge clk); vld = 1'b1; dest = 48'h1;
    @(negedge clk); dest = 48'hFFFF_FFFF_FFFF;
    @(negedge clk); vld = 1'b0;
    repeat (2) @(negedge clk);

    tag = "R5";
    set_sa(0, 48'h0605_0403_0201 & 48'hFFFF_FFFF_FFFE);
    set_sa(1, 48'hA1B2_C3D4_E5F6);
    set_sa(3, 48'h0000_0000_0100);
    for (int k = 0; k < 4; k++) strobe({sa_hi[k*16 +: 16], sa_lo[k*32 +: 32]});
    strobe(48'h0);
    strobe(48'h1234_5678_9ABC);

    tag = "R6";
    strobe(48'hFFFF_FFFF_FFFF);
    no_bcast = 1'b1;
    strobe(48'hFFFF_FFFF_FFFF);

    tag = "R7";
    copy_all = 1'b1;
    strobe(48'hFFFF_FFFF_FFFF);
    strobe(48'h1234_5678_9ABC);
    strobe(rnd_mc());
    copy_all = 1'b0; no_bcast = 1'b0;

    tag = "R4";
    hlo = '1; hhi = '1;
    for (int i = 0; i < 20; i++) strobe(rnd_mc());
    hash_en = 1'b1;
    for (int i = 0; i < 20; i++) strobe(rnd_mc());

    tag = "R3";
    hlo = '1; hhi = '0;
    for (int i = 0; i < 40; i++) strobe(rnd_mc());
    hlo = '0; hhi = '1;
    for (int i = 0; i < 40; i++) strobe(rnd_mc());

    tag = "R2";
    for (int i = 0; i < 300; i++) begin
      logic [47:0] a;
      int n;
      a = rnd_mc();
      n = hidx(a);
      hlo = '0; hhi = '0;
      if (i % 2 == 0) begin
        if (n < 32) hlo[n] = 1'b1; else hhi[n-32] = 1'b1;
      end else begin
        hlo = $urandom; hhi = $urandom;
      end
      strobe(a);
    end

    tag = "R8";
    hlo = '1; hhi = '1;
    set_sa(2, 48'h0000_0000_0033);
    strobe(48'h0000_0000_0033);
    set_sa(2, 48'hFFFF_FFFF_FFFF);
    no_bcast = 1'b1;
    strobe(48'hFFFF_FFFF_FFFF);
    no_bcast = 1'b0;
    strobe(48'hFFFF_FFFF_FFFF);

    tag = "R9";
    @(negedge clk); vld = 1'b1; dest = 48'h0000_0000_0033; hash_en = 1'b0;
    set_sa(2, 48'h0);
    @(negedge clk); vld = 1'b0; copy_all = 1'b1; hash_en = 1'b1;
    @(negedge clk); copy_all = 1'b0;
    @(negedge clk); vld = 1'b1; dest = 48'hFFFF_FFFF_FFFF;
    @(negedge clk); vld = 1'b0; no_bcast = 1'b1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule